// File: doc/BRIEF.md
# Single-Channel Byte DMA Engine with Interrupts

The engine copies a programmed number of bytes from a source address to a destination address, one byte at a time, over a simple request/ready memory port. Software programs it through eight 32-bit word registers selected by a 3-bit word index. A two-bit mode field chooses, for each side, whether that side is memory or a peripheral. A memory side steps its address by one byte per transfer. A peripheral side keeps a fixed address and waits for its request line before each byte.

When the transfer finishes, or when a bus error ends it early, the engine records the outcome in a read-only status word. It also sets a pending interrupt bit for the event. An enable mask selects which pending bits drive the single interrupt output, and a write-one-to-clear register removes pending bits. While a transfer runs, software can follow its progress by reading the source or destination register. Either read returns the number of bytes written so far.

Top module: `dma_xfer_unit`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `memReq` is 0.
- R2: A write to index 0 with bit 0 set starts a transfer. Bits [2:1] of that write give the mode: 00 memory→memory, 01 memory→peripheral, 10 peripheral→memory, 11 peripheral→peripheral. The transfer length in bytes comes from index 3. When all bytes are written, status (index 4) bit 0 becomes 1. A length of 0 completes at once with no bus access.
- R3: For byte i the read address is base+i on a memory source and base on a peripheral source. The destination follows the same rule. The byte written equals the byte read. `memReq`, `memWe` and `memAddr` hold steady until `memRdy`.
- R4: A peripheral source issues no read while `srcPerReq` is low. A peripheral destination issues no write while `dstPerReq` is low.
- R5: A read of index 1 or index 2 returns the count of bytes written so far, not the programmed address.
- R6: A read that ends with `memErr` stops the transfer without writing that byte. It sets status bit 1 and leaves status bit 0 clear.
- R7: A write that ends with `memErr` stops the transfer without counting that byte. It sets status bit 2 and leaves status bit 0 clear.
- R8: Each event sets its pending bit in index 7, whatever the enable mask (index 5) holds. The bits are 0 complete, 1 source error, 2 destination error. `irq` is the OR of the pending bits ANDed with the enable bits.
- R9: Writing index 6 clears each pending bit whose data bit is 1 and leaves the others unchanged.
- R10: A new start clears the status bits and the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regIdx | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regIdx (combinational) |
| memReq | output | 1 | Bus request, held until memRdy |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address |
| memWData | output | 8 | Write data |
| memRdy | input | 1 | Bus response for the current request |
| memRData | input | 8 | Read data, valid with memRdy |
| memErr | input | 1 | Error response, valid with memRdy |
| srcPerReq | input | 1 | Source peripheral ready for a byte |
| dstPerReq | input | 1 | Destination peripheral ready for a byte |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume that the bus raises `memRdy` only while a request is outstanding. They also assume that software does not rewrite the mode field, or start a new transfer, while a bus request is waiting. The one exception is a restart, which the checker excludes explicitly. The bench memory model answers each request exactly one cycle after seeing it and raises errors only at one armed address. Control writes are issued only when the engine is idle or parked waiting for a held-low peripheral request. Source and destination regions are kept disjoint, so read data is a fixed function of the address.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
  localparam int REG_W  = 32;
  localparam int DATA_W = 8;
  localparam int EV_N   = 3;   // complete, source error, destination error

  localparam logic [2:0] IDX_CTRL   = 3'd0;
  localparam logic [2:0] IDX_SRC    = 3'd1;
  localparam logic [2:0] IDX_DST    = 3'd2;
  localparam logic [2:0] IDX_SIZE   = 3'd3;
  localparam logic [2:0] IDX_STAT   = 3'd4;
  localparam logic [2:0] IDX_INTEN  = 3'd5;
  localparam logic [2:0] IDX_INTCLR = 3'd6;
  localparam logic [2:0] IDX_PEND   = 3'd7;

  typedef struct packed {
    logic clrRun;
    logic latchData;
    logic incCount;
    logic setDone;
    logic setSrcErr;
    logic setDstErr;
  } dmaStrb_t;
endpackage

// File: rtl/dma_ctrl.sv
`timescale 1ns/1ps
module dma_ctrl
  import dma_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     enBit,
  input  logic     srcPer,
  input  logic     dstPer,
  input  logic     sizeZero,
  input  logic     lastByte,
  input  logic     memRdy,
  input  logic     memErr,
  input  logic     srcPerReq,
  input  logic     dstPerReq,
  output logic     memReq,
  output logic     memWe,
  output logic     useDst,
  output dmaStrb_t strb
);
  typedef enum logic [2:0] {S_IDLE, S_SRCWAIT, S_READ, S_DSTWAIT, S_WRITE} state_t;
  state_t st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt    = st;
    memReq = 1'b0;
    memWe  = 1'b0;
    useDst = 1'b0;
    strb   = '0;
    case (st)
      S_IDLE: ;
      S_SRCWAIT: if (!srcPer || srcPerReq) nxt = S_READ;
      S_READ: begin
        memReq = 1'b1;
        if (memRdy) begin
          if (memErr) begin
            strb.setSrcErr = 1'b1;
            nxt = S_IDLE;
          end else begin
            strb.latchData = 1'b1;
            nxt = S_DSTWAIT;
          end
        end
      end
      S_DSTWAIT: begin
        useDst = 1'b1;
        if (!dstPer || dstPerReq) nxt = S_WRITE;
      end
      S_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        useDst = 1'b1;
        if (memRdy) begin
          if (memErr) begin
            strb.setDstErr = 1'b1;
            nxt = S_IDLE;
          end else begin
            strb.incCount = 1'b1;
            if (lastByte) begin
              strb.setDone = 1'b1;
              nxt = S_IDLE;
            end else begin
              nxt = S_SRCWAIT;
            end
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
    // a control write clearing the enable aborts the run
    if (!enBit) nxt = S_IDLE;
    // a start always wins and restarts from a clean state
    if (startReq) begin
      strb        = '0;
      strb.clrRun = 1'b1;
      memReq      = 1'b0;
      memWe       = 1'b0;
      if (sizeZero) begin
        strb.setDone = 1'b1;
        nxt = S_IDLE;
      end else begin
        nxt = S_SRCWAIT;
      end
    end
  end
endmodule

// File: rtl/dma_dpath.sv
`timescale 1ns/1ps
module dma_dpath
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regIdx,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  dmaStrb_t          strb,
  input  logic              useDst,
  input  logic [DATA_W-1:0] memRData,
  output logic [REG_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic              startReq,
  output logic              enBit,
  output logic              srcPer,
  output logic              dstPer,
  output logic              sizeZero,
  output logic              lastByte,
  output logic              irq,
  output logic [1:0]        modeBits,
  output logic [EV_N-1:0]   statusBits,
  output logic [EV_N-1:0]   pendBits,
  output logic [REG_W-1:0]  countVal,
  output logic [REG_W-1:0]  sizeVal
);
  logic [2:0]        ctrlReg;
  logic [REG_W-1:0]  srcBase, dstBase;
  logic [EV_N-1:0]   intEn;
  logic [DATA_W-1:0] dataHold;
  logic [EV_N-1:0]   evVec, clrMask;

  wire wrCtrl = regWrEn && (regIdx == IDX_CTRL);

  assign startReq = wrCtrl && regWrData[0];
  assign enBit    = ctrlReg[0];
  assign modeBits = ctrlReg[2:1];
  assign srcPer   = ctrlReg[2];
  assign dstPer   = ctrlReg[1];
  assign sizeZero = (sizeVal == '0);
  assign lastByte = ((countVal + REG_W'(1)) == sizeVal);
  assign evVec    = {strb.setDstErr, strb.setSrcErr, strb.setDone};
  assign clrMask  = (regWrEn && regIdx == IDX_INTCLR) ? regWrData[EV_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      srcBase <= '0;
      dstBase <= '0;
      sizeVal <= '0;
      intEn   <= '0;
    end else if (regWrEn) begin
      case (regIdx)
        IDX_CTRL:  ctrlReg <= regWrData[2:0];
        IDX_SRC:   srcBase <= regWrData;
        IDX_DST:   dstBase <= regWrData;
        IDX_SIZE:  sizeVal <= regWrData;
        IDX_INTEN: intEn   <= regWrData[EV_N-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
      dataHold <= '0;
    end else begin
      if (strb.clrRun)         countVal <= '0;
      else if (strb.incCount)  countVal <= countVal + REG_W'(1);
      if (strb.latchData)      dataHold <= memRData;
    end
  end

  // per-event status and pending bits; an event outranks a clear in the same cycle
  for (genvar e = 0; e < EV_N; e++) begin : g_ev
    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusBits[e] <= 1'b0;
        pendBits[e]   <= 1'b0;
      end else begin
        if (evVec[e])          statusBits[e] <= 1'b1;
        else if (strb.clrRun)  statusBits[e] <= 1'b0;
        if (evVec[e])          pendBits[e]   <= 1'b1;
        else if (clrMask[e])   pendBits[e]   <= 1'b0;
      end
    end
  end

  assign irq      = |(pendBits & intEn);
  assign memWData = dataHold;
  assign memAddr  = useDst ? (dstBase + (dstPer ? '0 : countVal))
                           : (srcBase + (srcPer ? '0 : countVal));

  always_comb begin
    case (regIdx)
      IDX_CTRL:  regRdData = {{(REG_W-3){1'b0}}, ctrlReg};
      IDX_SRC,
      IDX_DST:   regRdData = countVal;
      IDX_SIZE:  regRdData = sizeVal;
      IDX_STAT:  regRdData = {{(REG_W-EV_N){1'b0}}, statusBits};
      IDX_INTEN: regRdData = {{(REG_W-EV_N){1'b0}}, intEn};
      IDX_PEND:  regRdData = {{(REG_W-EV_N){1'b0}}, pendBits};
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/dma_xfer_unit.sv
`timescale 1ns/1ps
module dma_xfer_unit
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regIdx,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              memReq,
  output logic              memWe,
  output logic [REG_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memRdy,
  input  logic [DATA_W-1:0] memRData,
  input  logic              memErr,
  input  logic              srcPerReq,
  input  logic              dstPerReq,
  output logic              irq
);
  dmaStrb_t         strb;
  logic             useDst, startReq, enBit, srcPer, dstPer, sizeZero, lastByte;
  logic [1:0]       modeBits;
  logic [EV_N-1:0]  statusBits, pendBits;
  logic [REG_W-1:0] countVal, sizeVal;

  dma_ctrl u_ctrl (
    .clk, .rstN, .startReq, .enBit, .srcPer, .dstPer, .sizeZero, .lastByte,
    .memRdy, .memErr, .srcPerReq, .dstPerReq, .memReq, .memWe, .useDst, .strb
  );

  dma_dpath u_dpath (
    .clk, .rstN, .regWrEn, .regIdx, .regWrData, .regRdData, .strb, .useDst,
    .memRData, .memAddr, .memWData, .startReq, .enBit, .srcPer, .dstPer,
    .sizeZero, .lastByte, .irq, .modeBits, .statusBits, .pendBits, .countVal, .sizeVal
  );
endmodule

// File: rtl/dma_xfer_unit_chk.sv
`timescale 1ns/1ps
module dma_xfer_unit_chk
  import dma_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [2:0]       regIdx,
  input logic             memReq,
  input logic             memWe,
  input logic [REG_W-1:0] memAddr,
  input logic             memRdy,
  input logic             srcPerReq,
  input logic             dstPerReq,
  input logic             irq,
  input logic [1:0]       modeBits,
  input logic [EV_N-1:0]  statusBits,
  input logic [EV_N-1:0]  pendBits,
  input logic [REG_W-1:0] countVal,
  input logic [REG_W-1:0] sizeVal
);
  wire ctrlWr = regWrEn && (regIdx == IDX_CTRL);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memRdy && !ctrlWr |=> memReq && $stable(memWe) && $stable(memAddr));

  p_src_pace_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) && !memWe && modeBits[1] |-> $past(srcPerReq));

  p_dst_pace_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) && memWe && modeBits[0] |-> $past(dstPerReq));

  p_done_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBits[0]) |-> countVal == sizeVal);

  p_no_wr_after_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    statusBits[1] |-> !(memReq && memWe));

  p_err_not_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    statusBits[2] |-> !statusBits[0]);

  p_irq_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> pendBits != '0);
endmodule

bind dma_xfer_unit dma_xfer_unit_chk u_chk (
  .clk, .rstN, .regWrEn, .regIdx, .memReq, .memWe, .memAddr, .memRdy,
  .srcPerReq, .dstPerReq, .irq, .modeBits, .statusBits, .pendBits, .countVal, .sizeVal
);

// File: tb/dma_xfer_unit_bench.sv
`timescale 1ns/1ps
module dma_xfer_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regIdx = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq, memWe, irq;
  logic [31:0] memAddr;
  logic [7:0]  memWData;
  logic        memRdy = 1'b0;
  logic [7:0]  memRData = '0;
  logic        memErr = 1'b0;
  logic        srcPerReq = 1'b0;
  logic        dstPerReq = 1'b0;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  // error injection and pacing controls, set from the main sequence
  bit          errArm = 1'b0;
  bit          errWrite = 1'b0;
  logic [31:0] errAddr = '0;
  int          srcPace = 0, dstPace = 0;   // 0 always high, 1 random, 2 held low

  logic [31:0] logAddr [0:63];
  logic [7:0]  logData [0:63];
  int          logN = 0;
  logic [2:0]  pendModel = '0;
  logic [2:0]  enModel = '0;

  dma_xfer_unit u_dma_xfer_unit (.*);

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return a[7:0] * 8'd7 + 8'd3;
  endfunction

  // one-cycle-latency bus model; only successful writes are logged
  always @(negedge clk) begin
    if (!rstN) begin
      memRdy = 1'b0; memErr = 1'b0;
    end else if (memReq && !memRdy) begin
      memRdy   = 1'b1;
      memRData = memByte(memAddr);
      memErr   = errArm && (memAddr == errAddr) && (memWe == errWrite);
      if (memWe && !memErr && logN < 64) begin
        logAddr[logN] = memAddr;
        logData[logN] = memWData;
        logN++;
      end
    end else begin
      memRdy = 1'b0; memErr = 1'b0;
    end
    srcPerReq = (srcPace == 0) || (srcPace == 1 && ($urandom % 2) == 1);
    dstPerReq = (dstPace == 0) || (dstPace == 1 && ($urandom % 3) != 0);
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    regIdx = idx; regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] idx, output logic [31:0] data);
    regIdx = idx;
    #0.5;
    data = regRdData;
  endtask

  task automatic waitOutcome();
    logic [31:0] st;
    for (int t = 0; t < 4000; t++) begin
      readReg(3'd4, st);
      if (st != 0) return;
      @(negedge clk);
    end
  endtask

  // starts a transfer and checks outcome, count, write stream and interrupts
  task automatic doXfer(input logic [1:0] mode, input logic [31:0] src, input logic [31:0] dst,
                        input int size, input int errAt, input bit errW, input logic [2:0] en,
                        input logic [2:0] clr);
    logic [31:0] v;
    logic [2:0]  expStat;
    int          expCnt;
    bit          streamOk;
    errArm = (errAt >= 0);
    errWrite = errW;
    errAddr = errW ? dst + errAt : src + errAt;
    logN = 0;
    writeReg(3'd1, src);
    writeReg(3'd2, dst);
    writeReg(3'd3, size);
    writeReg(3'd5, {29'd0, en});
    enModel = en;
    writeReg(3'd0, {29'd0, mode, 1'b1});
    waitOutcome();
    repeat (3) @(negedge clk);
    if (errAt < 0) begin expStat = 3'b001; expCnt = size; end
    else begin expStat = errW ? 3'b100 : 3'b010; expCnt = errAt; end
    readReg(3'd4, v);
    check(errAt < 0 ? "R2" : (errW ? "R7" : "R6"), "status", v, {29'd0, expStat});
    readReg(3'd1, v);
    check("R5", "src readback count", v, expCnt);
    readReg(3'd2, v);
    check("R5", "dst readback count", v, expCnt);
    check(errAt < 0 ? "R2" : (errW ? "R7" : "R6"), "bytes written", logN, expCnt);
    streamOk = 1'b1;
    for (int i = 0; i < logN; i++) begin
      if (logAddr[i] !== (mode[0] ? dst : dst + i) ||
          logData[i] !== memByte(mode[1] ? src : src + i)) begin
        if (streamOk)
          $display("FAIL R3 byte %0d: actual addr %0h data %0h expected addr %0h data %0h",
                   i, logAddr[i], logData[i], (mode[0] ? dst : dst + i), memByte(mode[1] ? src : src + i));
        streamOk = 1'b0;
      end
    end
    nChecks++;
    if (!streamOk) nFails++;
    pendModel = pendModel | expStat;
    readReg(3'd7, v);
    check("R8", "pending", v, {29'd0, pendModel});
    check("R8", "irq", irq, |(pendModel & enModel));
    writeReg(3'd6, {29'd0, clr});
    pendModel = pendModel & ~clr;
    readReg(3'd7, v);
    check("R9", "pending after clear", v, {29'd0, pendModel});
    check("R9", "irq after clear", irq, |(pendModel & enModel));
    errArm = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      readReg(i[2:0], v);
      check("R1", "reset register", v, 32'd0);
    end
    check("R1", "reset irq", irq, 1'b0);
    check("R1", "reset memReq", memReq, 1'b0);

    // directed cases
    doXfer(2'b00, 32'd10, 32'd140, 16, -1, 1'b0, 3'b001, 3'b000);  // plain copy, complete enabled
    doXfer(2'b00, 32'd0, 32'd128, 0, -1, 1'b0, 3'b111, 3'b001);    // zero length
    doXfer(2'b00, 32'd20, 32'd150, 12, 5, 1'b0, 3'b000, 3'b000);   // read error, masked
    // R8: source error still pending while masked; irq stays low
    readReg(3'd7, v);
    check("R8", "masked pending", v[1], 1'b1);
    check("R8", "masked irq", irq, 1'b0);
    doXfer(2'b00, 32'd30, 32'd160, 9, 0, 1'b1, 3'b110, 3'b010);    // write error on first byte
    doXfer(2'b00, 32'd40, 32'd170, 10, 7, 1'b1, 3'b100, 3'b111);   // write error mid-way

    // R4 and R10: peripheral source parked while its request is low
    srcPace = 2;
    errArm = 1'b0;
    logN = 0;
    writeReg(3'd1, 32'd5);
    writeReg(3'd2, 32'd130);
    writeReg(3'd3, 32'd4);
    writeReg(3'd0, 32'h5);    // mode 10, enable
    readReg(3'd4, v);
    check("R10", "status cleared by restart", v, 32'd0);
    readReg(3'd1, v);
    check("R10", "count cleared by restart", v, 32'd0);
    repeat (40) @(negedge clk);
    check("R4", "no bus request while source idle", memReq, 1'b0);
    check("R4", "no bytes while source idle", logN, 0);
    srcPace = 1;
    waitOutcome();
    repeat (3) @(negedge clk);
    readReg(3'd4, v);
    check("R4", "paced transfer completes", v, 32'd1);
    check("R4", "paced byte count", logN, 4);
    writeReg(3'd6, 32'd7);
    pendModel = '0;

    // R4: peripheral destination parked while its request is low
    dstPace = 2;
    logN = 0;
    writeReg(3'd3, 32'd3);
    writeReg(3'd0, 32'h3);    // mode 01, enable
    repeat (40) @(negedge clk);
    check("R4", "no write while destination idle", logN, 0);
    readReg(3'd2, v);
    check("R5", "count while destination idle", v, 32'd0);
    dstPace = 1;
    waitOutcome();
    repeat (3) @(negedge clk);
    check("R4", "destination paced byte count", logN, 3);
    writeReg(3'd6, 32'd7);
    pendModel = '0;

    // random transfers over all modes
    for (int k = 0; k < 12; k++) begin
      logic [1:0] m;
      int sz, ea;
      m = 2'($urandom % 4);
      sz = 1 + ($urandom % 32);
      ea = (($urandom % 4) == 0 && m == 2'b00) ? int'($urandom % sz) : -1;
      doXfer(m, 32'($urandom % 64), 32'(128 + ($urandom % 64)), sz, ea, 1'($urandom % 2),
             3'($urandom % 8), 3'($urandom % 8));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule